// File: doc/BRIEF.md
# Majority-Clocked Three-Register Keystream Generator

This block produces a pseudo-random keystream, one bit per step. It holds three binary linear feedback shift registers of 19, 22 and 23 bits. Each has XOR feedback from a fixed tap set and one fixed clocking bit. The three clocking bits are put to a majority vote. On a keystream step, a register shifts only when its own clocking bit agrees with the vote. This makes the stepping irregular: two or three registers move on every step, and never fewer.

A pulse on `init_start` clears all three registers and opens a load phase. During that phase the block takes `KEY_BITS + FRAME_BITS` secret and frame bits over a valid/ready stream, key first and each word least significant bit first. Each accepted bit steps all three registers together, without the vote, and is XORed into the new bit 0 of every register. The load stream stalls while `in_valid` is low; `in_ready` is high only during the load phase.

After the last load bit, the block runs `WARM_STEPS` majority steps on its own and shows no output. It then raises `out_valid`. The output stream presents `out_bit`, the XOR of the three top bits. A majority step happens only on a cycle with `out_valid && out_ready`. While `out_ready` is low the state is frozen, and `out_bit` and `agree_mask` hold their values.

Top module: `ks_majority_gen`

## Requirements
- R1: After a synchronous reset, `in_ready`, `out_valid` and `out_bit` are 0.
- R2: After an `init_start` pulse, `in_ready` is 1 until exactly `KEY_BITS + FRAME_BITS` bits have been accepted (`in_valid && in_ready`); cycles with `in_valid` low accept nothing. `in_ready` and `out_valid` are never 1 together.
- R3: Each accepted load bit b steps all three registers regardless of the vote, and bit 0 of each becomes its feedback XOR b. The load order is key bit 0 to key bit KEY_BITS-1, then frame bit 0 upward.
- R4: `out_valid` stays 0 for exactly `WARM_STEPS` cycles after the cycle that accepts the last load bit, and is 1 from the next cycle.
- R5: The feedback taps are bits {18,17,16,13}, {21,20} and {22,21,20,7}, and the clocking bits are bit 8, bit 10 and bit 10. `agree_mask[k]` is 1 exactly when register k's clocking bit equals the majority of the three, and it always has at least two bits set.
- R6: `out_bit` is the XOR of bit 18, bit 21 and bit 22 of the three registers. The keystream for a fixed key and frame matches an independent reference model.
- R7: While `out_valid` is 1 and `out_ready` is 0, the state holds: `out_bit` and `agree_mask` stay stable.
- R8: An all-zero key and frame leave every register at zero, so the keystream is all zeros and `agree_mask` is 3'b111.
- R9: Over many steps, each register agrees with the majority (and so steps) in 70% to 80% of the steps, close to 3/4.
- R10: `init_start` restarts from any phase: on the next cycle `out_valid` is 0 and `in_ready` is 1, and a fresh load gives the keystream of the new key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| init_start | input | 1 | Pulse: clear the registers and begin loading |
| in_valid | input | 1 | Load bit offered |
| in_bit | input | 1 | Load bit value |
| in_ready | output | 1 | Block accepts load bits (load phase) |
| out_valid | output | 1 | Keystream bit available (run phase) |
| out_ready | input | 1 | Consumer takes the bit; a majority step happens |
| out_bit | output | 1 | Keystream bit, XOR of the three top bits |
| agree_mask | output | 3 | Per register: clocking bit equals majority |

## Verification
The bench builds the block with its default parameters: 64 key bits, 22 frame bits and 100 warm-up steps. With these values it can compare the block bit for bit with a reference built in the bench for several keys. It can also count the exact warm-up length and drive the all-zero key case. The short load and warm-up phases leave room for a 6000-step run that measures how often each register steps.

// File: rtl/ks_pkg.sv
package ks_pkg;
  localparam int NUM_LANES = 3;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_WARM = 2'd2,
    PH_RUN  = 2'd3
  } phase_e;

  function automatic int lane_len(input int idx);
    case (idx)
      0:       return 19;
      1:       return 22;
      default: return 23;
    endcase
  endfunction

  // feedback tap masks, bit n set when stage n feeds the XOR
  function automatic logic [31:0] lane_taps(input int idx);
    case (idx)
      0:       return 32'h0007_2000;
      1:       return 32'h0030_0000;
      default: return 32'h0070_0080;
    endcase
  endfunction

  function automatic int lane_cpos(input int idx);
    case (idx)
      0:       return 8;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/lfsr_lane.sv
module lfsr_lane #(
  parameter int          LEN  = 19,
  parameter logic [31:0] TAPS = 32'h0007_2000,
  parameter int          CPOS = 8
) (
  input  logic clk,
  input  logic clear,
  input  logic shift,
  input  logic inject,
  output logic clk_bit,
  output logic msb
);
  logic [LEN-1:0] state_q;
  logic           fb;

  assign fb = ^(state_q & TAPS[LEN-1:0]);

  always_ff @(posedge clk) begin
    if (clear)      state_q <= '0;
    else if (shift) state_q <= {state_q[LEN-2:0], fb ^ inject};
  end

  assign clk_bit = state_q[CPOS];
  assign msb     = state_q[LEN-1];
endmodule

// File: rtl/maj3_vote.sv
module maj3_vote (
  input  logic [2:0] bits_i,
  output logic [2:0] agree_o
);
  logic maj;
  assign maj = (bits_i[0] & bits_i[1]) | (bits_i[0] & bits_i[2]) | (bits_i[1] & bits_i[2]);

  for (genvar k = 0; k < 3; k++) begin : g_agree
    assign agree_o[k] = ~(bits_i[k] ^ maj);
  end
endmodule

// File: rtl/ks_majority_gen.sv
module ks_majority_gen
  import ks_pkg::*;
#(
  parameter int KEY_BITS   = 64,
  parameter int FRAME_BITS = 22,
  parameter int WARM_STEPS = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       init_start,
  input  logic       in_valid,
  input  logic       in_bit,
  output logic       in_ready,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       out_bit,
  output logic [2:0] agree_mask
);
  localparam int LOAD_BITS = KEY_BITS + FRAME_BITS;
  localparam int CNT_MAX   = (LOAD_BITS > WARM_STEPS) ? LOAD_BITS : WARM_STEPS;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  phase_e                 phase_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [NUM_LANES-1:0]   clk_bits, msbs, shift_en, agree;
  logic                   accept, inject, clear;

  assign accept = in_valid && (phase_q == PH_LOAD);
  assign inject = accept && in_bit;
  assign clear  = rst || init_start;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    lfsr_lane #(
      .LEN (lane_len(g)),
      .TAPS(lane_taps(g)),
      .CPOS(lane_cpos(g))
    ) i_lane (
      .clk    (clk),
      .clear  (clear),
      .shift  (shift_en[g]),
      .inject (inject),
      .clk_bit(clk_bits[g]),
      .msb    (msbs[g])
    );
  end

  maj3_vote i_vote (
    .bits_i (clk_bits),
    .agree_o(agree)
  );

  always_comb begin
    case (phase_q)
      PH_LOAD: shift_en = {NUM_LANES{accept}};
      PH_WARM: shift_en = agree;
      PH_RUN:  shift_en = out_ready ? agree : '0;
      default: shift_en = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clear) begin
      phase_q <= rst ? PH_IDLE : PH_LOAD;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_LOAD: if (accept) begin
          if (cnt_q == CNT_W'(LOAD_BITS - 1)) begin
            phase_q <= PH_WARM;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_WARM: begin
          if (cnt_q == CNT_W'(WARM_STEPS - 1)) begin
            phase_q <= PH_RUN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign in_ready   = (phase_q == PH_LOAD);
  assign out_valid  = (phase_q == PH_RUN);
  assign out_bit    = ^msbs;
  assign agree_mask = agree;
endmodule

// File: rtl/ks_majority_gen_chk.sv
module ks_majority_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       init_start,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_bit,
  input logic [2:0] agree_mask
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!out_valid && !in_ready && !out_bit));

  a_r2_not_both: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  a_r5_two_step: assert property (@(posedge clk) disable iff (rst)
    $countones(agree_mask) >= 2);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !init_start) |=>
      (out_valid && $stable(out_bit) && $stable(agree_mask)));

  a_r10_restart: assert property (@(posedge clk) disable iff (rst)
    init_start |=> (in_ready && !out_valid));
endmodule

bind ks_majority_gen ks_majority_gen_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .init_start(init_start),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bit   (out_bit),
  .agree_mask(agree_mask)
);

// File: tb/test_ks_majority_gen.sv
module test_ks_majority_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WARM       = 100;

  logic       clk = 1'b0;
  logic       rst, init_start, in_valid, in_bit, out_ready;
  logic       in_ready, out_valid, out_bit;
  logic [2:0] agree_mask;

  int total = 0;
  int bad   = 0;

  logic [18:0] m0;
  logic [21:0] m1;
  logic [22:0] m2;

  always #(CLK_PERIOD/2) clk = ~clk;

  ks_majority_gen i_ks_majority_gen (
    .clk(clk), .rst(rst), .init_start(init_start),
    .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit), .agree_mask(agree_mask)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model, written from R3, R5, R6
  function automatic logic [2:0] m_agree();
    logic a, b, c, mj;
    a = m0[8]; b = m1[10]; c = m2[10];
    mj = (a & b) | (a & c) | (b & c);
    return {c == mj, b == mj, a == mj};
  endfunction

  function automatic logic m_out();
    return m0[18] ^ m1[21] ^ m2[22];
  endfunction

  task automatic m_step(input logic [2:0] en, input logic inj);
    logic f0, f1, f2;
    f0 = m0[18] ^ m0[17] ^ m0[16] ^ m0[13];
    f1 = m1[21] ^ m1[20];
    f2 = m2[22] ^ m2[21] ^ m2[20] ^ m2[7];
    if (en[0]) m0 = {m0[17:0], f0 ^ inj};
    if (en[1]) m1 = {m1[20:0], f1 ^ inj};
    if (en[2]) m2 = {m2[21:0], f2 ^ inj};
  endtask

  task automatic t_reset();
    rst = 1'b1; init_start = 0; in_valid = 0; in_bit = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 in_ready after reset", in_ready, 0);
    check("R1 out_valid after reset", out_valid, 0);
    check("R1 out_bit after reset", out_bit, 0);
  endtask

  task automatic t_load(input logic [63:0] key, input logic [21:0] frame, input int gap);
    int n;
    logic b;
    @(negedge clk); init_start = 1'b1;
    @(negedge clk); init_start = 1'b0;
    check("R10 in_ready after init", in_ready, 1);
    check("R10 out_valid after init", out_valid, 0);
    m0 = '0; m1 = '0; m2 = '0;
    for (int i = 0; i < 86; i++) begin
      if (gap != 0 && (i % gap) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 ready during stall", in_ready, 1);
      end
      b = (i < 64) ? key[i] : frame[i-64];
      in_valid = 1'b1; in_bit = b;
      @(negedge clk);
      m_step(3'b111, b);
    end
    in_valid = 1'b0; in_bit = 0;
    check("R2 ready drops after last bit", in_ready, 0);
    check("R4 no output at warm start", out_valid, 0);
    n = 0;
    while (!out_valid && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check("R4 warm-up length", n, WARM);
    for (int i = 0; i < WARM; i++) m_step(m_agree(), 1'b0);
  endtask

  task automatic t_stream(input int steps, input int stall_every, input string tag);
    int errs;
    errs = 0;
    for (int i = 0; i < steps; i++) begin
      out_ready = !(stall_every != 0 && (i % stall_every) == 1);
      #1;
      if (out_bit !== m_out() || agree_mask !== m_agree() || out_valid !== 1'b1) begin
        errs++;
        if (errs == 1)
          $display("FAIL %s step %0d: actual bit=%0b mask=%0b expected bit=%0b mask=%0b",
                   tag, i, out_bit, agree_mask, m_out(), m_agree());
      end
      if (out_ready) m_step(m_agree(), 1'b0);
      @(negedge clk);
    end
    out_ready = 0;
    total++;
    if (errs != 0) bad++;
  endtask

  task automatic t_zero();
    int nz;
    t_load(64'd0, 22'd0, 0);
    nz = 0;
    out_ready = 1'b1;
    for (int i = 0; i < 64; i++) begin
      if (out_bit !== 1'b0 || agree_mask !== 3'b111) nz++;
      @(negedge clk);
    end
    out_ready = 0;
    check("R8 zero state stays zero", nz, 0);
  endtask

  task automatic t_stats();
    int cnt0, cnt1, cnt2, under;
    cnt0 = 0; cnt1 = 0; cnt2 = 0; under = 0;
    t_load(64'h0123_4567_89ab_cdef, 22'h2a5a5, 0);
    out_ready = 1'b1;
    for (int i = 0; i < 6000; i++) begin
      cnt0 += int'(agree_mask[0]);
      cnt1 += int'(agree_mask[1]);
      cnt2 += int'(agree_mask[2]);
      if ($countones(agree_mask) < 2) under++;
      @(negedge clk);
    end
    out_ready = 0;
    check("R5 never fewer than two stepping", under, 0);
    check("R9 lane0 step rate", (cnt0 >= 4200 && cnt0 <= 4800), 1);
    check("R9 lane1 step rate", (cnt1 >= 4200 && cnt1 <= 4800), 1);
    check("R9 lane2 step rate", (cnt2 >= 4200 && cnt2 <= 4800), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    // R3 R6: reference keystream for a fixed key and frame
    t_load(64'hfedc_ba98_7654_3210, 22'h134, 0);
    t_stream(300, 0, "R6 keystream key A");
    // R2 R3: load with stalls, R7: output back-pressure
    t_load(64'h5a5a_0f0f_c3c3_9669, 22'h3ffff, 3);
    t_stream(300, 4, "R7 keystream with stalls");
    // R10: restart in mid-run, then new key
    t_load(64'h0000_0000_0000_0001, 22'h1, 0);
    t_stream(20, 0, "R10 keystream before restart");
    t_load(64'h8000_0000_1234_5678, 22'h2bcde, 2);
    t_stream(200, 3, "R10 keystream after restart");
    t_zero();
    t_stats();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule